// File: doc/BRIEF.md
# OUT Endpoint Ping-Pong Receive Buffer

This block holds the data of one device-side OUT endpoint. It has one or two equal banks. The bus side presents each incoming packet as a start strobe, a run of byte strobes and an end strobe. If the bus-side bank is free when the packet starts, the bytes go into that bank and the packet is answered with ACK. If the CPU still owns the bank, the packet is answered with NAK and its bytes are dropped.

The CPU side always looks at one current bank. It sees a received flag, an ownership flag, a remaining-byte count, a read-allowed status and a data port that shows the next unread byte. A read strobe consumes that byte. A release strobe hands the bank back to the bus side and moves to the other bank. If that bank already holds a packet, the received flag is raised again in the next cycle. The received flag, gated by an enable input, drives the interrupt.

The bus-side and CPU-side pointers move independently. A full bit per bank decides which side owns that bank.

Top module: `out_ep_rxbuf`

## Requirements
- R1: After a synchronous active-low reset, `rx_flag`, `fifo_ctl`, `irq`, `hs_ack`, `hs_nak`, `ovf_flag` and `rd_allowed` are 0, `byte_cnt` is 0, and both pointers return to bank 0. A stored packet is emptied by reset.
- R2: A packet that starts while the bus-side bank is free is stored. In the cycle after its `pkt_end` strobe, `hs_ack` is 1 for one cycle. When that packet lands in the CPU's current bank, `fifo_ctl` and `rx_flag` go to 1 in the same cycle and `byte_cnt` equals the stored length.
- R3: `irq` is 1 exactly when `rx_flag` is 1 and `rx_int_en` is 1.
- R4: A one on `rx_flag_clr` clears `rx_flag` at the next edge. It leaves `fifo_ctl`, `byte_cnt` and the data unchanged. When the strobe is low, the flag is held.
- R5: `rd_data` shows the current bank's bytes in arrival order. Each `rd_en` while `byte_cnt` is nonzero advances to the next byte and lowers `byte_cnt` by one. `rd_allowed` is 1 exactly while `byte_cnt` is nonzero.
- R6: An `rd_en` while `byte_cnt` is 0 changes neither `byte_cnt` nor `fifo_ctl`.
- R7: A `fifo_ctl_clr` strobe while `fifo_ctl` is 1 frees the current bank and moves the CPU side to the other bank (with one bank, it stays on bank 0). If the new bank is empty, `fifo_ctl` and `rx_flag` read 0 in the next cycle.
- R8: With two banks, the bus side fills one bank while the CPU holds the other. A release onto a bank that is already full shows `rx_flag`=1, `fifo_ctl`=1 and that bank's count in the next cycle.
- R9: A packet that starts while the bus-side bank is still owned by the CPU gets `hs_nak` for one cycle, in the cycle after `pkt_end`. Its bytes are discarded. `hs_ack` and `hs_nak` are never 1 together.
- R10: A packet longer than `BANK_BYTES` keeps its first `BANK_BYTES` bytes, reports `byte_cnt`=`BANK_BYTES` and sets `ovf_flag` while that bank is current. A packet that fits leaves `ovf_flag` at 0.
- R11: A zero-length packet (start followed by end) is ACKed and takes a bank. It sets `rx_flag` and `fifo_ctl` with `byte_cnt`=0 and `rd_allowed`=0.
- R12: A `fifo_ctl_clr` while `fifo_ctl` is 0 is ignored, and the CPU pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_start | input | 1 | Start of an OUT data packet |
| pkt_byte | input | 1 | `pkt_data` carries a packet byte |
| pkt_data | input | 8 | Packet byte |
| pkt_end | input | 1 | End of the packet; handshake follows |
| hs_ack | output | 1 | One-cycle ACK answer |
| hs_nak | output | 1 | One-cycle NAK answer |
| rx_int_en | input | 1 | Interrupt enable for the received flag |
| rx_flag_clr | input | 1 | Write-one clear of the received flag |
| fifo_ctl_clr | input | 1 | Release the current bank and advance |
| rd_en | input | 1 | Consume the byte on `rd_data` |
| rx_flag | output | 1 | Received-data flag |
| fifo_ctl | output | 1 | Current bank is owned by the CPU |
| byte_cnt | output | $clog2(BANK_BYTES+1) | Unread bytes in the current bank |
| rd_allowed | output | 1 | Current bank has unread bytes |
| rd_data | output | 8 | Next unread byte |
| ovf_flag | output | 1 | Current bank's packet was truncated |
| irq | output | 1 | Endpoint interrupt |

## Verification
The main path is driven by a sequence of packets of lengths 1, 3, 4 (exactly a bank), 5 and 7 (longer than a bank) and 0. Each is drained and released in turn. Byte order, truncation at the bank edge and an empty bank that is still owned can each fail on their own. Because the packets alternate between the two banks, a pointer that does not toggle shows up as stale data. A ping-pong sequence fills both banks and then sends a third packet. That separates a correct NAK-and-discard from a packet that overwrites a held bank. It also checks that the received flag returns at once when the CPU releases onto a full bank. Spurious release and read strobes are applied to empty state and then observed through a later packet.

// File: rtl/rxb_pkg.sv
// Shared types for the OUT endpoint receive buffer.
// Assumes nothing beyond byte-wide packet data.
package rxb_pkg;
    typedef logic [7:0] byte_t;

    // Handshake answer registered after a packet ends.
    typedef enum logic [1:0] {
        HS_NONE = 2'd0,
        HS_ACK  = 2'd1,
        HS_NAK  = 2'd2
    } hs_e;
endpackage

// File: rtl/rxb_bank_mem.sv
// Byte storage for NUM_BANKS banks of BANK_BYTES bytes each.
// One synchronous write port, one asynchronous read port.
// Assumes BANK_BYTES is a power of two and NUM_BANKS is 1 or 2.
module rxb_bank_mem
    import rxb_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    parameter int AW         = $clog2(BANK_BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output byte_t         rd_data
);
    byte_t bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        byte_t mem [BANK_BYTES];

        // Store a packet byte into this bank when it is the write target.
        always_ff @(posedge clk) begin
            if (we && wr_bank == 1'(b)) mem[wr_addr] <= wr_data;
        end

        assign bank_rd[b] = mem[rd_addr];
    end

    // Select the bank the CPU side is reading.
    assign rd_data = (NUM_BANKS == 2 && rd_bank) ? bank_rd[NUM_BANKS-1] : bank_rd[0];
endmodule

// File: rtl/rxb_bus_wr.sv
// Bus-side packet writer: decides acceptance at packet start, counts and
// stores bytes up to the bank size, flags truncation, answers ACK or NAK,
// and toggles the bus-side bank pointer after each stored packet.
// Assumes pkt_end arrives in a cycle of its own after the last byte.
module rxb_bus_wr
    import rxb_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    parameter int AW         = $clog2(BANK_BYTES),
    parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             pkt_byte,
    input  logic             pkt_end,
    input  logic             wr_full,
    output logic             wr_ptr,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic             done,
    output logic [CNT_W-1:0] done_len,
    output logic             done_ovf,
    output logic             hs_ack,
    output logic             hs_nak
);
    logic             in_pkt, accept, ovf_pend;
    logic [CNT_W-1:0] wr_cnt;
    hs_e              hs_q;

    assign mem_we   = in_pkt && pkt_byte && accept && (wr_cnt < CNT_W'(BANK_BYTES));
    assign mem_addr = wr_cnt[AW-1:0];
    assign done     = in_pkt && pkt_end && accept;
    assign done_len = wr_cnt;
    assign done_ovf = ovf_pend;

    // Track one packet: acceptance, byte count, truncation and bank toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt   <= 1'b0;
            accept   <= 1'b0;
            ovf_pend <= 1'b0;
            wr_cnt   <= '0;
            wr_ptr   <= 1'b0;
        end else if (pkt_start) begin
            in_pkt   <= 1'b1;
            accept   <= !wr_full;
            ovf_pend <= 1'b0;
            wr_cnt   <= '0;
        end else if (in_pkt && pkt_byte && accept) begin
            if (wr_cnt < CNT_W'(BANK_BYTES)) wr_cnt <= wr_cnt + CNT_W'(1);
            else                             ovf_pend <= 1'b1;
        end else if (in_pkt && pkt_end) begin
            in_pkt <= 1'b0;
            if (accept && NUM_BANKS == 2) wr_ptr <= ~wr_ptr;
        end
    end

    // Register the handshake answer for the cycle after the packet ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                hs_q <= HS_NONE;
        else if (in_pkt && pkt_end) hs_q <= accept ? HS_ACK : HS_NAK;
        else                       hs_q <= HS_NONE;
    end

    assign hs_ack = (hs_q == HS_ACK);
    assign hs_nak = (hs_q == HS_NAK);
endmodule

// File: rtl/rxb_cpu_rd.sv
// CPU-side reader: holds the current-bank pointer, the read offset and the
// received flag; produces the remaining count and the bank handover.
// Assumes cur_set never coincides with cur_full (bus writes only free banks).
module rxb_cpu_rd #(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    parameter int AW         = $clog2(BANK_BYTES),
    parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cur_full,
    input  logic [CNT_W-1:0] cur_len,
    input  logic             nxt_full,
    input  logic             cur_set,
    input  logic             rx_flag_clr,
    input  logic             fifo_ctl_clr,
    input  logic             rd_en,
    output logic             rd_ptr,
    output logic             handover,
    output logic [AW-1:0]    rd_addr,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             rd_allowed,
    output logic             rx_flag
);
    logic [CNT_W-1:0] rd_idx;

    assign handover   = fifo_ctl_clr && cur_full;
    assign byte_cnt   = cur_full ? (cur_len - rd_idx) : '0;
    assign rd_allowed = (byte_cnt != '0);
    assign rd_addr    = rd_idx[AW-1:0];

    // Advance the read offset and move to the next bank on handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx <= '0;
            rd_ptr <= 1'b0;
        end else if (handover) begin
            rd_idx <= '0;
            if (NUM_BANKS == 2) rd_ptr <= ~rd_ptr;
        end else if (rd_en && rd_allowed) begin
            rd_idx <= rd_idx + CNT_W'(1);
        end
    end

    // Received flag: reloaded on handover, set on fill, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)           rx_flag <= 1'b0;
        else if (handover)    rx_flag <= nxt_full;
        else if (cur_set)     rx_flag <= 1'b1;
        else if (rx_flag_clr) rx_flag <= 1'b0;
    end
endmodule

// File: rtl/out_ep_rxbuf.sv
// OUT endpoint receive buffer top: owns the per-bank full, length and
// overflow state and wires the bus writer, CPU reader and storage.
// Assumes NUM_BANKS is 1 or 2 and BANK_BYTES is a power of two >= 2.
module out_ep_rxbuf
    import rxb_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_BYTES = 64,
    localparam int AW        = $clog2(BANK_BYTES),
    localparam int CNT_W     = $clog2(BANK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_start,
    input  logic             pkt_byte,
    input  logic [7:0]       pkt_data,
    input  logic             pkt_end,
    output logic             hs_ack,
    output logic             hs_nak,
    input  logic             rx_int_en,
    input  logic             rx_flag_clr,
    input  logic             fifo_ctl_clr,
    input  logic             rd_en,
    output logic             rx_flag,
    output logic             fifo_ctl,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             rd_allowed,
    output logic [7:0]       rd_data,
    output logic             ovf_flag,
    output logic             irq
);
    logic                 wr_ptr, rd_ptr, nxt_ptr, handover;
    logic                 mem_we, done, done_ovf;
    logic [AW-1:0]        mem_addr, rd_addr;
    logic [CNT_W-1:0]     done_len, cur_len;
    logic                 wr_full, cur_full, cur_ovf, nxt_full, cur_set;
    logic [NUM_BANKS-1:0] full_q, ovf_q;
    logic [CNT_W-1:0]     len_q [NUM_BANKS];

    assign nxt_ptr = (NUM_BANKS == 2) ? ~rd_ptr : rd_ptr;
    assign cur_set = done && (wr_ptr == rd_ptr);

    // Pick per-bank state for the bus-side, current and next banks.
    always_comb begin
        wr_full  = 1'b0;
        cur_full = 1'b0;
        cur_ovf  = 1'b0;
        cur_len  = '0;
        nxt_full = done && (wr_ptr == nxt_ptr) && (NUM_BANKS == 2);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (wr_ptr == 1'(b)) wr_full = full_q[b];
            if (rd_ptr == 1'(b)) begin
                cur_full = full_q[b];
                cur_ovf  = ovf_q[b];
                cur_len  = len_q[b];
            end
            if (NUM_BANKS == 2 && nxt_ptr == 1'(b) && full_q[b]) nxt_full = 1'b1;
        end
    end

    // Per-bank ownership: set at end of a stored packet, cleared on handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
            ovf_q  <= '0;
            for (int b = 0; b < NUM_BANKS; b++) len_q[b] <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (done && wr_ptr == 1'(b)) begin
                    full_q[b] <= 1'b1;
                    ovf_q[b]  <= done_ovf;
                    len_q[b]  <= done_len;
                end else if (handover && rd_ptr == 1'(b)) begin
                    full_q[b] <= 1'b0;
                end
            end
        end
    end

    rxb_bus_wr #(
        .NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES), .AW(AW), .CNT_W(CNT_W)
    ) u_bus_wr (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_byte(pkt_byte),
        .pkt_end(pkt_end), .wr_full(wr_full), .wr_ptr(wr_ptr), .mem_we(mem_we),
        .mem_addr(mem_addr), .done(done), .done_len(done_len), .done_ovf(done_ovf),
        .hs_ack(hs_ack), .hs_nak(hs_nak)
    );

    rxb_cpu_rd #(
        .NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES), .AW(AW), .CNT_W(CNT_W)
    ) u_cpu_rd (
        .clk(clk), .rst_n(rst_n), .cur_full(cur_full), .cur_len(cur_len),
        .nxt_full(nxt_full), .cur_set(cur_set), .rx_flag_clr(rx_flag_clr),
        .fifo_ctl_clr(fifo_ctl_clr), .rd_en(rd_en), .rd_ptr(rd_ptr),
        .handover(handover), .rd_addr(rd_addr), .byte_cnt(byte_cnt),
        .rd_allowed(rd_allowed), .rx_flag(rx_flag)
    );

    rxb_bank_mem #(
        .NUM_BANKS(NUM_BANKS), .BANK_BYTES(BANK_BYTES), .AW(AW)
    ) u_mem (
        .clk(clk), .we(mem_we), .wr_bank(wr_ptr), .wr_addr(mem_addr),
        .wr_data(pkt_data), .rd_bank(rd_ptr), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign fifo_ctl = cur_full;
    assign ovf_flag = cur_full && cur_ovf;
    assign irq      = rx_flag && rx_int_en;
endmodule

// File: rtl/out_ep_rxbuf_chk.sv
// Protocol checker for out_ep_rxbuf, attached with bind below.
// Assumes the same clock and reset as the buffer.
module out_ep_rxbuf_chk #(
    parameter int CNT_W      = 7,
    parameter int BANK_BYTES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_end,
    input logic             hs_ack,
    input logic             hs_nak,
    input logic             rx_flag_clr,
    input logic             fifo_ctl_clr,
    input logic             rd_en,
    input logic             rx_flag,
    input logic             fifo_ctl,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             rd_allowed
);
    AST_ACK_NAK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hs_ack, hs_nak}));                                    // R9
    AST_ACK_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack && !fifo_ctl_clr |-> $past(fifo_ctl) || fifo_ctl);       // R2
    AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_allowed && !fifo_ctl_clr
        |=> byte_cnt == $past(byte_cnt) - CNT_W'(1));                   // R5
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag_clr && !fifo_ctl_clr && !pkt_end |=> !rx_flag);        // R4
    AST_FLAG_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag |-> fifo_ctl);                                          // R7
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cnt <= CNT_W'(BANK_BYTES));                                // R10
endmodule

bind out_ep_rxbuf out_ep_rxbuf_chk #(.CNT_W(CNT_W), .BANK_BYTES(BANK_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end), .hs_ack(hs_ack), .hs_nak(hs_nak),
    .rx_flag_clr(rx_flag_clr), .fifo_ctl_clr(fifo_ctl_clr), .rd_en(rd_en),
    .rx_flag(rx_flag), .fifo_ctl(fifo_ctl), .byte_cnt(byte_cnt), .rd_allowed(rd_allowed)
);

// File: tb/out_ep_rxbuf_test.sv
`timescale 1ns/1ps
// Self-checking bench: table-driven packet sweep, then directed cases.
module out_ep_rxbuf_test;
    localparam int BB = 4;
    localparam int CW = $clog2(BB + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic pkt_start = 0, pkt_byte = 0, pkt_end = 0;
    logic [7:0] pkt_data = '0;
    logic rx_int_en = 0, rx_flag_clr = 0, fifo_ctl_clr = 0, rd_en = 0;
    logic hs_ack, hs_nak, rx_flag, fifo_ctl, rd_allowed, ovf_flag, irq;
    logic [CW-1:0] byte_cnt;
    logic [7:0] rd_data;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    out_ep_rxbuf #(.NUM_BANKS(2), .BANK_BYTES(BB)) uut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_byte(pkt_byte),
        .pkt_data(pkt_data), .pkt_end(pkt_end), .hs_ack(hs_ack), .hs_nak(hs_nak),
        .rx_int_en(rx_int_en), .rx_flag_clr(rx_flag_clr), .fifo_ctl_clr(fifo_ctl_clr),
        .rd_en(rd_en), .rx_flag(rx_flag), .fifo_ctl(fifo_ctl), .byte_cnt(byte_cnt),
        .rd_allowed(rd_allowed), .rd_data(rd_data), .ovf_flag(ovf_flag), .irq(irq)
    );

    // Packet sweep: length, first byte, expected count, expected overflow.
    localparam int VEC [6][4] = '{
        '{1, 'h11, 1, 0}, '{3, 'h21, 3, 0}, '{4, 'h31, 4, 0},
        '{5, 'h41, 4, 1}, '{7, 'h51, 4, 1}, '{0, 'h61, 0, 0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Send a packet; returns with the handshake cycle visible.
    task automatic send_pkt(input int len, input int base);
        pkt_start = 1; tick(); pkt_start = 0;
        for (int i = 0; i < len; i++) begin
            pkt_byte = 1; pkt_data = 8'(base + i); tick();
        end
        pkt_byte = 0; pkt_end = 1; tick(); pkt_end = 0;
    endtask

    task automatic read_byte();
        rd_en = 1; tick(); rd_en = 0;
    endtask

    task automatic release_bank();
        fifo_ctl_clr = 1; tick(); fifo_ctl_clr = 0;
    endtask

    initial begin
        #(100000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk("R1 rx_flag", rx_flag, 0);     chk("R1 fifo_ctl", fifo_ctl, 0);
        chk("R1 byte_cnt", byte_cnt, 0);   chk("R1 irq", irq, 0);
        chk("R1 hs", {hs_ack, hs_nak}, 0); chk("R1 rd_allowed", rd_allowed, 0);
        rst_n = 1; tick();

        // Table sweep: R2 R5 R6 R7 R10 R11
        for (int v = 0; v < 6; v++) begin
            send_pkt(VEC[v][0], VEC[v][1]);
            chk("R2 ack", hs_ack, 1);       chk("R9 no nak", hs_nak, 0);
            chk("R2 fifo_ctl", fifo_ctl, 1); chk("R2 rx_flag", rx_flag, 1);
            chk("R2 R11 byte_cnt", byte_cnt, VEC[v][2]);
            chk("R10 ovf_flag", ovf_flag, VEC[v][3]);
            for (int i = 0; i < VEC[v][2]; i++) begin
                chk("R5 rd_data", rd_data, (VEC[v][1] + i) & 8'hff);
                chk("R5 rd_allowed", rd_allowed, 1);
                read_byte();
                chk("R5 byte_cnt", byte_cnt, VEC[v][2] - i - 1);
            end
            chk("R5 R11 rd_allowed low", rd_allowed, 0);
            read_byte();
            chk("R6 byte_cnt", byte_cnt, 0); chk("R6 fifo_ctl", fifo_ctl, 1);
            release_bank();
            chk("R7 fifo_ctl", fifo_ctl, 0); chk("R7 rx_flag", rx_flag, 0);
        end

        // R3 and R4: interrupt gating and write-one clear
        send_pkt(2, 'h70);
        chk("R3 irq disabled", irq, 0);
        rx_int_en = 1; #1;
        chk("R3 irq enabled", irq, 1);
        tick();
        chk("R4 flag held", rx_flag, 1);
        rx_flag_clr = 1; tick(); rx_flag_clr = 0;
        chk("R4 rx_flag", rx_flag, 0); chk("R4 fifo_ctl", fifo_ctl, 1);
        chk("R4 byte_cnt", byte_cnt, 2); chk("R4 rd_data", rd_data, 'h70);
        chk("R3 irq after clear", irq, 0);
        release_bank();

        // R8 and R9: ping-pong with a NAKed third packet
        send_pkt(2, 'h80);
        chk("R8 first ack", hs_ack, 1);
        rx_flag_clr = 1; tick(); rx_flag_clr = 0;
        send_pkt(3, 'h90);
        chk("R8 second ack", hs_ack, 1);
        chk("R8 flag not raised by other bank", rx_flag, 0);
        send_pkt(2, 'hA0);
        chk("R9 nak", hs_nak, 1); chk("R9 no ack", hs_ack, 0);
        chk("R8 first bank data", rd_data, 'h80);
        read_byte(); read_byte();
        release_bank();
        chk("R8 rx_flag immediate", rx_flag, 1); chk("R8 fifo_ctl", fifo_ctl, 1);
        chk("R8 byte_cnt", byte_cnt, 3); chk("R9 discarded", rd_data, 'h90);
        release_bank();
        chk("R7 both empty", fifo_ctl, 0);

        // R12: release while not owned must not move the CPU pointer
        release_bank();
        send_pkt(1, 'hB5);
        chk("R12 fifo_ctl", fifo_ctl, 1); chk("R12 rd_data", rd_data, 'hB5);

        // R1: reset empties a stored packet
        rst_n = 0; tick(); rst_n = 1;
        chk("R1 reset empties", fifo_ctl, 0); chk("R1 reset flag", rx_flag, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule